// File: doc/BRIEF.md
# Interrupt Pin Dispatch Engine

This block turns per-pin interrupt events into outgoing interrupt messages. Each of the input pins carries a saturating assertion count. Sources raise or lower a pin with assert, deassert or pulse events. A message is attempted only when a pin's count leaves zero. The routing entry for each pin is a 64-bit word supplied from outside. It provides the vector, destination, destination mode, delivery mode, trigger mode and mask.

Level-triggered pins are gated by a remote-pending bit that this block owns. The bit is set when a level message is queued, and further attempts are suppressed while it stays set. An end-of-interrupt event carrying a vector clears the bit on every matching pin. Any of those pins that is still asserted is re-delivered.

Accepted attempts are queued per pin. They leave over a single valid/ready message port, lowest pin number first. Register access to the routing entries and the receiving controllers sit outside this block.

Top module: `irq_dispatch`

## Requirements
- R1: After reset no message is offered (msg_valid_o low) and err_o is low.
- R2: Event kind codes are 0 assert, 1 deassert, 2 pulse and 3 no operation. An assert raises the pin's count by one, and a delivery attempt occurs only when the count goes from 0 to 1. The message takes its fields from the entry: vector from bits 7:0, delivery mode from bits 10:8, destination mode from bit 11 (1 means logical), trigger mode from bit 15 (1 means level) and destination from bits 63:56.
- R3: Every other count transition (1 to 2, 2 to 1, 1 to 0) produces no message.
- R4: A pulse applies an assert and then a deassert in the same cycle. At count 0 it makes one delivery attempt and leaves the count at 0.
- R5: When mask bit 16 of the entry is set, a delivery attempt is dropped and no message for it is sent later.
- R6: For a level entry, an attempt made while the pin's remote-pending bit is set is suppressed. Otherwise the attempt sets the bit and queues a message.
- R7: An end-of-interrupt with vector V clears the remote-pending bit of every pin whose bit is set and whose entry vector equals V. Each such pin whose count is above 0 gets a new attempt. An end-of-interrupt that matches no pin changes nothing.
- R8: An event with pin number at or above NUM_PINS, or with kind code 3, changes no state.
- R9: The count saturates at 2^CNT_W-1 on assert and at 0 on deassert instead of wrapping.
- R10: A deassert at count 0 sets err_o, which stays set until reset.
- R11: Queued attempts are offered in ascending pin order, one message per accepted handshake. msg_valid_o stays high until msg_ready_i accepts the message.
- R12: Further attempts on a pin whose message is already queued merge into that single queued message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ev_valid_i | input | 1 | Pin event strobe |
| ev_pin_i | input | PIN_W (6) | Pin number of the event |
| ev_kind_i | input | 2 | 0 assert, 1 deassert, 2 pulse, 3 no operation |
| route_i | input | NUM_PINS*64 | Routing entries, pin n at bits 64n+63:64n |
| eoi_valid_i | input | 1 | End-of-interrupt strobe |
| eoi_vec_i | input | 8 | End-of-interrupt vector |
| msg_valid_o | output | 1 | Message offered |
| msg_ready_i | input | 1 | Message accepted |
| msg_vec_o | output | 8 | Message vector |
| msg_dest_o | output | 8 | Message destination |
| msg_dmode_o | output | 3 | Delivery mode |
| msg_dst_logical_o | output | 1 | Destination mode, 1 logical |
| msg_level_o | output | 1 | Trigger mode, 1 level |
| err_o | output | 1 | Sticky deassert-at-zero flag |

## Verification
A wrong count is not visible at once. It shows only at the next event on that pin, as a message that is missing or extra. The bench therefore follows each count-changing sequence with a probing assert, and checks one or two cycles later whether a message appears. A stuck or lost remote-pending bit shows up as an extra message before the end-of-interrupt, or a missing one after it. Wrong queue arbitration appears as messages in the wrong order when several pins wait behind a stalled ready.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int ENTRY_W    = 64;
  localparam int VEC_W      = 8;
  localparam int DEST_W     = 8;
  localparam int DMODE_W    = 3;
  localparam int VEC_LSB    = 0;
  localparam int DMODE_LSB  = 8;
  localparam int DSTLOG_BIT = 11;
  localparam int TRIG_BIT   = 15;
  localparam int MASK_BIT   = 16;
  localparam int DEST_LSB   = 56;

  typedef enum logic [1:0] {
    EV_ASSERT   = 2'd0,
    EV_DEASSERT = 2'd1,
    EV_PULSE    = 2'd2,
    EV_NONE     = 2'd3
  } ev_kind_e;

  typedef struct packed {
    logic               level;
    logic               dst_logical;
    logic [DMODE_W-1:0] dmode;
    logic [DEST_W-1:0]  dest;
    logic [VEC_W-1:0]   vec;
  } msg_t;

  function automatic msg_t entry_to_msg(input logic [ENTRY_W-1:0] e);
    msg_t m;
    m.level       = e[TRIG_BIT];
    m.dst_logical = e[DSTLOG_BIT];
    m.dmode       = e[DMODE_LSB +: DMODE_W];
    m.dest        = e[DEST_LSB +: DEST_W];
    m.vec         = e[VEC_LSB +: VEC_W];
    return m;
  endfunction
endpackage

// File: rtl/irq_pin_ctrl.sv
module irq_pin_ctrl
  import irq_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [VEC_W-1:0] vec_i,
  input  logic             masked_i,
  input  logic             level_i,
  input  logic             ev_hit_i,
  input  ev_kind_e         ev_kind_i,
  input  logic             eoi_valid_i,
  input  logic [VEC_W-1:0] eoi_vec_i,
  input  logic             issue_i,
  output logic             pend_o,
  output logic             uflow_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_up, cnt_d;
  logic             rpend_q, rpend_d, pend_q, pend_d;
  logic             eoi_hit, rp_mid, do_inc, do_dec;
  logic             att_eoi, att_ev, deliver, enqueue;

  always_comb begin
    // end-of-interrupt is applied before the pin event of the same cycle
    eoi_hit = eoi_valid_i && rpend_q && (vec_i == eoi_vec_i);
    rp_mid  = rpend_q && !eoi_hit;
    att_eoi = eoi_hit && (cnt_q != '0);

    do_inc = ev_hit_i && (ev_kind_i == EV_ASSERT || ev_kind_i == EV_PULSE);
    do_dec = ev_hit_i && (ev_kind_i == EV_DEASSERT || ev_kind_i == EV_PULSE);

    cnt_up  = (do_inc && cnt_q != CNT_MAX) ? cnt_q + CNT_ONE : cnt_q;
    att_ev  = do_inc && (cnt_q == '0);
    uflow_o = do_dec && (cnt_up == '0);
    cnt_d   = (do_dec && cnt_up != '0) ? cnt_up - CNT_ONE : cnt_up;

    deliver = (att_eoi || att_ev) && !masked_i;
    enqueue = deliver && !(level_i && rp_mid);
    rpend_d = rp_mid || (deliver && level_i);
    pend_d  = (pend_q && !issue_i) || enqueue;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      rpend_q <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      rpend_q <= rpend_d;
      pend_q  <= pend_d;
    end
  end

  assign pend_o = pend_q;

  // R9
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_hit_i && ev_kind_i == EV_DEASSERT && cnt_q == '0) |=> (cnt_q == '0));
  // R9
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_hit_i && ev_kind_i == EV_ASSERT && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));
  // R6
  rpend_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rpend_q && !eoi_valid_i) |=> rpend_q);
  // R7
  eoi_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_valid_i && rpend_q && vec_i == eoi_vec_i && cnt_q == '0 && !ev_hit_i)
    |=> !rpend_q);
  // R11
  pend_until_issue_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !issue_i) |=> pend_q);
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N     = 32,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     req_i,
  output logic [N-1:0]     gnt_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);
  always_comb begin
    gnt_o = req_i & (~req_i + N'(1));
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
    any_o = |req_i;
  end

  // R11
  grant_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o) && ((gnt_o & ~req_i) == '0) && (any_o == (gnt_o != '0)));
endmodule

// File: rtl/irq_dispatch.sv
module irq_dispatch
  import irq_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int CNT_W    = 4,
  parameter int PIN_W    = $clog2(NUM_PINS) + 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        ev_valid_i,
  input  logic [PIN_W-1:0]            ev_pin_i,
  input  logic [1:0]                  ev_kind_i,
  input  logic [NUM_PINS*ENTRY_W-1:0] route_i,
  input  logic                        eoi_valid_i,
  input  logic [VEC_W-1:0]            eoi_vec_i,
  output logic                        msg_valid_o,
  input  logic                        msg_ready_i,
  output logic [VEC_W-1:0]            msg_vec_o,
  output logic [DEST_W-1:0]           msg_dest_o,
  output logic [DMODE_W-1:0]          msg_dmode_o,
  output logic                        msg_dst_logical_o,
  output logic                        msg_level_o,
  output logic                        err_o
);
  localparam int IDX_W = $clog2(NUM_PINS);

  logic [ENTRY_W-1:0]  ent [NUM_PINS];
  logic [NUM_PINS-1:0] pend, gnt, issue, uflow;
  logic [IDX_W-1:0]    sel;
  logic                any_pend, pin_ok, err_q;
  ev_kind_e            kind;
  msg_t                msg;
  logic                unused_route;

  assign kind   = ev_kind_e'(ev_kind_i);
  assign pin_ok = ev_valid_i && (ev_pin_i < PIN_W'(NUM_PINS));

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    assign ent[g] = route_i[g*ENTRY_W +: ENTRY_W];
    irq_pin_ctrl #(.CNT_W(CNT_W)) u_pin (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .vec_i      (ent[g][VEC_LSB +: VEC_W]),
      .masked_i   (ent[g][MASK_BIT]),
      .level_i    (ent[g][TRIG_BIT]),
      .ev_hit_i   (pin_ok && (ev_pin_i[IDX_W-1:0] == IDX_W'(g))),
      .ev_kind_i  (kind),
      .eoi_valid_i(eoi_valid_i),
      .eoi_vec_i  (eoi_vec_i),
      .issue_i    (issue[g]),
      .pend_o     (pend[g]),
      .uflow_o    (uflow[g])
    );
  end

  irq_prio_pick #(.N(NUM_PINS), .IDX_W(IDX_W)) u_pick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .req_i (pend),
    .gnt_o (gnt),
    .idx_o (sel),
    .any_o (any_pend)
  );

  assign issue = gnt & {NUM_PINS{msg_ready_i}};
  assign msg   = entry_to_msg(ent[sel]);

  assign msg_valid_o       = any_pend;
  assign msg_vec_o         = msg.vec;
  assign msg_dest_o        = msg.dest;
  assign msg_dmode_o       = msg.dmode;
  assign msg_dst_logical_o = msg.dst_logical;
  assign msg_level_o       = msg.level;
  assign unused_route      = ^route_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= err_q || (|uflow);
  end
  assign err_o = err_q;

  // R11
  msg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_valid_o && !msg_ready_i) |=> msg_valid_o);
  // R10
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
  // R8
  bad_pin_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_valid_i && !pin_ok && !eoi_valid_i && !msg_valid_o) |=> !msg_valid_o);
endmodule

// File: tb/irq_dispatch_tb.sv
`timescale 1ns/1ps
module irq_dispatch_tb;
  localparam int NP = 32;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          ev_valid_i = 1'b0;
  logic [5:0]    ev_pin_i = '0;
  logic [1:0]    ev_kind_i = 2'd3;
  logic [NP*64-1:0] route_i;
  logic          eoi_valid_i = 1'b0;
  logic [7:0]    eoi_vec_i = '0;
  logic          msg_valid_o, msg_ready_i, msg_dst_logical_o, msg_level_o, err_o;
  logic [7:0]    msg_vec_o, msg_dest_o;
  logic [2:0]    msg_dmode_o;

  int total = 0;
  int bad = 0;
  logic [20:0] exp_q [$];
  string       tag_q [$];

  always #2.5 clk_i = ~clk_i;

  irq_dispatch u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .ev_valid_i(ev_valid_i), .ev_pin_i(ev_pin_i),
    .ev_kind_i(ev_kind_i), .route_i(route_i), .eoi_valid_i(eoi_valid_i),
    .eoi_vec_i(eoi_vec_i), .msg_valid_o(msg_valid_o), .msg_ready_i(msg_ready_i),
    .msg_vec_o(msg_vec_o), .msg_dest_o(msg_dest_o), .msg_dmode_o(msg_dmode_o),
    .msg_dst_logical_o(msg_dst_logical_o), .msg_level_o(msg_level_o), .err_o(err_o)
  );

  function automatic logic [63:0] mk(input logic [7:0] vec, input logic [2:0] dm,
      input logic dlog, input logic lvl, input logic msk, input logic [7:0] dest);
    logic [63:0] e = '0;
    e[7:0] = vec; e[10:8] = dm; e[11] = dlog; e[15] = lvl; e[16] = msk; e[63:56] = dest;
    return e;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_entry(input int pin, input logic [63:0] e);
    route_i[pin*64 +: 64] = e;
  endtask

  // expected message from the bench's own copy of the entry
  task automatic expect_msg(input int pin, input string tag);
    logic [63:0] e = route_i[pin*64 +: 64];
    exp_q.push_back({e[15], e[11], e[10:8], e[63:56], e[7:0]});
    tag_q.push_back(tag);
  endtask

  task automatic ev(input int pin, input logic [1:0] kind);
    ev_valid_i = 1'b1; ev_pin_i = 6'(pin); ev_kind_i = kind;
    @(posedge clk_i); #1;
    ev_valid_i = 1'b0; ev_kind_i = 2'd3;
  endtask

  task automatic eoi(input logic [7:0] v);
    eoi_valid_i = 1'b1; eoi_vec_i = v;
    @(posedge clk_i); #1;
    eoi_valid_i = 1'b0;
  endtask

  task automatic quiet(input string tag);
    repeat (4) @(posedge clk_i);
    #1;
    chk(exp_q.size() == 0, tag, exp_q.size(), 0);
  endtask

  // monitor: a transfer happens at the next edge when valid and ready are high now
  always @(negedge clk_i) begin
    if (rst_ni && msg_valid_o && msg_ready_i) begin
      logic [20:0] act;
      act = {msg_level_o, msg_dst_logical_o, msg_dmode_o, msg_dest_o, msg_vec_o};
      if (exp_q.size() == 0) begin
        chk(1'b0, "unexpected message", act, 0);
      end else begin
        logic [20:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(act == e, t, act, e);
      end
    end
  end

  initial begin
    #1000000;
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    msg_ready_i = 1'b1;
    for (int p = 0; p < NP; p++) set_entry(p, mk(8'(8'h80 + p), 3'd0, 1'b0, 1'b0, 1'b1, 8'h00));
    repeat (3) @(posedge clk_i);
    #1;
    chk(msg_valid_o == 1'b0, "R1 valid after reset", msg_valid_o, 0);
    chk(err_o == 1'b0, "R1 err after reset", err_o, 0);
    rst_ni = 1'b1;
    @(posedge clk_i); #1;

    // R2 edge delivery and field positions
    set_entry(5, mk(8'h41, 3'd1, 1'b1, 1'b0, 1'b0, 8'h12));
    expect_msg(5, "R2 edge fields");
    ev(5, 2'd0);
    quiet("R2 drained");

    // R3 other transitions ignored
    ev(5, 2'd0); ev(5, 2'd1); ev(5, 2'd1);
    quiet("R3 no message on 1-2-1-0");
    expect_msg(5, "R3 fresh 0 to 1");
    ev(5, 2'd0);
    quiet("R3 drained");
    ev(5, 2'd1);

    // R4 pulse
    set_entry(6, mk(8'h42, 3'd0, 1'b0, 1'b0, 1'b0, 8'h34));
    expect_msg(6, "R4 pulse delivers");
    ev(6, 2'd2);
    quiet("R4 drained");
    expect_msg(6, "R4 count back at zero");
    ev(6, 2'd0);
    quiet("R4 second drained");
    ev(6, 2'd1);

    // R5 mask
    set_entry(4, mk(8'h43, 3'd2, 1'b0, 1'b0, 1'b1, 8'h56));
    ev(4, 2'd0);
    quiet("R5 masked dropped");
    set_entry(4, mk(8'h43, 3'd2, 1'b0, 1'b0, 1'b0, 8'h56));
    quiet("R5 no late message on unmask");
    ev(4, 2'd1);
    expect_msg(4, "R5 unmasked delivers");
    ev(4, 2'd0);
    quiet("R5 drained");
    ev(4, 2'd1);

    // R6 / R7 level with remote-pending
    set_entry(7, mk(8'h50, 3'd0, 1'b1, 1'b1, 1'b0, 8'h9a));
    expect_msg(7, "R6 level first");
    ev(7, 2'd0);
    quiet("R6 level drained");
    ev(7, 2'd1); ev(7, 2'd0);
    quiet("R6 suppressed while pending");
    eoi(8'h51);
    quiet("R7 non-matching eoi ignored");
    expect_msg(7, "R7 eoi redelivers");
    eoi(8'h50);
    quiet("R7 first eoi drained");
    expect_msg(7, "R7 second eoi redelivers");
    eoi(8'h50);
    quiet("R7 second eoi drained");
    ev(7, 2'd1);
    eoi(8'h50);
    quiet("R7 eoi at count zero silent");
    expect_msg(7, "R6 pending cleared by eoi");
    ev(7, 2'd0);
    quiet("R6 after clear drained");

    // R7 two pins share a vector, redelivered in pin order
    set_entry(12, mk(8'h60, 3'd0, 1'b0, 1'b1, 1'b0, 8'h01));
    set_entry(13, mk(8'h60, 3'd0, 1'b0, 1'b1, 1'b0, 8'h02));
    expect_msg(13, "R7 pin13 first assert");
    ev(13, 2'd0);
    expect_msg(12, "R7 pin12 first assert");
    ev(12, 2'd0);
    quiet("R7 shared drained");
    expect_msg(12, "R7 shared eoi pin12");
    expect_msg(13, "R7 shared eoi pin13");
    eoi(8'h60);
    quiet("R7 shared eoi drained");

    // R8 out-of-range pin and no-op kind
    set_entry(8, mk(8'h44, 3'd0, 1'b0, 1'b0, 1'b0, 8'h77));
    ev(40, 2'd0);
    ev(8, 2'd3);
    quiet("R8 rejected events silent");
    ev(40, 2'd1);
    chk(err_o == 1'b0, "R8 rejected deassert no err", err_o, 0);
    expect_msg(8, "R8 pin8 count untouched");
    ev(8, 2'd0);
    quiet("R8 drained");

    // R9 saturation
    set_entry(10, mk(8'h45, 3'd0, 1'b0, 1'b0, 1'b0, 8'h10));
    expect_msg(10, "R9 first of many asserts");
    for (int i = 0; i < 17; i++) ev(10, 2'd0);
    quiet("R9 no wrap message");
    for (int i = 0; i < 14; i++) ev(10, 2'd1);
    quiet("R9 count still above zero");
    ev(10, 2'd1);
    chk(err_o == 1'b0, "R9 count was saturated at max", err_o, 0);
    expect_msg(10, "R9 fresh after saturation");
    ev(10, 2'd0);
    quiet("R9 drained");

    // R11 / R12 ordering and merge with ready stalled
    msg_ready_i = 1'b0;
    set_entry(20, mk(8'h46, 3'd0, 1'b0, 1'b0, 1'b0, 8'h20));
    set_entry(9,  mk(8'h47, 3'd0, 1'b0, 1'b0, 1'b0, 8'h09));
    set_entry(3,  mk(8'h48, 3'd0, 1'b0, 1'b0, 1'b0, 8'h03));
    set_entry(2,  mk(8'h49, 3'd0, 1'b0, 1'b0, 1'b0, 8'h02));
    ev(20, 2'd0); ev(9, 2'd0); ev(3, 2'd0);
    ev(2, 2'd0); ev(2, 2'd1); ev(2, 2'd0);
    repeat (3) @(posedge clk_i);
    #1;
    chk(msg_valid_o == 1'b1, "R11 valid held while stalled", msg_valid_o, 1);
    chk(msg_vec_o == 8'h49, "R11 lowest pin offered", msg_vec_o, 8'h49);
    expect_msg(2, "R12 merged pin2");
    expect_msg(3, "R11 order pin3");
    expect_msg(9, "R11 order pin9");
    expect_msg(20, "R11 order pin20");
    msg_ready_i = 1'b1;
    quiet("R11 ordered drained");

    // R10 sticky error
    set_entry(25, mk(8'h4a, 3'd0, 1'b0, 1'b0, 1'b0, 8'h25));
    chk(err_o == 1'b0, "R10 err low before", err_o, 0);
    ev(25, 2'd1);
    chk(err_o == 1'b1, "R10 err set", err_o, 1);
    repeat (5) @(posedge clk_i);
    #1;
    chk(err_o == 1'b1, "R10 err sticky", err_o, 1);
    expect_msg(25, "R10 count held at zero");
    ev(25, 2'd0);
    quiet("R10 drained");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule